// File: doc/BRIEF.md
# Serial Configuration Port with Sequential Readback

This block is the slave end of a three-wire serial control link. It holds a small bank of byte-wide configuration registers. A host frames each transfer with an active-low latch strobe, clocks it with a serial clock, shifts data in on a serial input line, and takes readback data from a serial output whose driver can be switched off. The first eight bits of every frame form a command: one direction bit, then a 7-bit register index. Data moves most significant bit first.

A write frame has sixteen bits. The data byte is stored when the latch strobe rises, and only if exactly sixteen bits arrived. Reads use a setup register instead of the command index. That register holds a sweep flag and a 7-bit target pointer. With the sweep flag clear, a read returns the byte the pointer selects. With the sweep flag set, a read streams registers 1, 2, ... up to the pointer value, back to back. The output stays undriven for the whole command byte. Each data bit is launched after a serial-clock falling edge, so the host can capture it on the next rising edge.

All three host inputs are brought into the system clock through synchronizer chains. Edges are detected from the synchronized samples, so the system clock must run at least eight times the serial clock rate. The contents of the bank are driven out in parallel to the functions they configure.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, the setup register (index 11) reads 0x01 (sweep flag 0, pointer 1). Every other register reads 0x00. The output enable is low.
- R2: A frame of exactly 16 serial clocks with direction bit 0 (bit 15 of the frame) stores bits 7..0 into the register given by bits 14..8. The store happens when the latch strobe rises.
- R3: A write frame that ends before its 16th bit, or that runs past it, changes no register.
- R4: The output enable stays low for the first 8 serial clocks of every frame.
- R5: With the sweep flag (bit 7 of register 11) clear, a read frame (direction bit 1) drives the register selected by the pointer (bits 6..0 of register 11). The byte goes out MSB first, one bit after each falling edge, starting after the 8th clock.
- R6: With the sweep flag set, a read frame streams registers 1 through the pointer value in ascending order, with no gap between bytes.
- R7: In a read frame, the index bits of the command and every input bit after the command have no effect on the returned data or on any register.
- R8: A read of an index at or above the bank size returns 0x00. A write to such an index changes nothing.
- R9: A write to register 11 takes effect for the next read frame.
- R10: When the latch strobe rises in the middle of a read, the output enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ml_i | input | 1 | Frame latch strobe, active low, asynchronous |
| mc_i | input | 1 | Serial clock, asynchronous |
| mdi_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| mdo_o | output | 1 | Serial data out |
| mdo_oe_o | output | 1 | Output enable for the serial data out driver |
| cfg_o | output | NUM_REGS*8 | Register bank contents, register k in bits 8k+7..8k |

## Verification
The bench targets frames of the wrong length. A write cut to 12 bits or stretched to 17 must leave the bank untouched. A design that commits on the 16th bit, or on any rising edge of the strobe, would corrupt the target register. Sweep reads are checked byte by byte against registers 1 to N. A design that starts from the pointer, skips a register at the byte boundary, or inserts a dead clock would shift every later byte. Read commands are also sent with a nonzero index, with noisy input after the command, and with a pointer beyond the bank. A design that decodes the index, absorbs the noise, or wraps the address would return the wrong byte. Finally, the output enable is watched during every command clock and after an aborted read, to catch a driver that turns on early or stays on.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int IDX_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = IDX_W + 1 + BYTE_W;
  localparam int CNT_W   = 5;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int    NUM_REGS  = 16,
  parameter int    SETUP_IDX = 11,
  parameter byte_t SETUP_RST = 8'h01,
  parameter byte_t REG_RST   = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  idx_t                       wr_addr,
  input  byte_t                      wr_data,
  input  idx_t                       rd_addr,
  output byte_t                      rd_data,
  output logic                       sweep_o,
  output idx_t                       ptr_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  byte_t regs [NUM_REGS];
  logic  wr_hit;
  logic  rd_hit;

  assign wr_hit = wr_en && ({1'b0, wr_addr} < LIMIT);
  assign rd_hit = {1'b0, rd_addr} < LIMIT;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam byte_t RV = (k == SETUP_IDX) ? SETUP_RST : REG_RST;
    always_ff @(posedge clk) begin
      if (rst) regs[k] <= RV;
      else if (wr_hit && (wr_addr[AW-1:0] == AW'(k))) regs[k] <= wr_data;
    end
    assign cfg_o[k*BYTE_W +: BYTE_W] = regs[k];
  end

  assign rd_data = rd_hit ? regs[rd_addr[AW-1:0]] : '0;
  assign sweep_o = regs[SETUP_IDX][BYTE_W-1];
  assign ptr_o   = regs[SETUP_IDX][IDX_W-1:0];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ml_rise,
  input  logic  ml_fall,
  input  logic  mc_rise,
  input  logic  mc_fall,
  input  logic  mdi,
  input  logic  sweep,
  input  idx_t  ptr,
  input  byte_t rd_data,
  output idx_t  rd_addr,
  output logic  wr_en,
  output idx_t  wr_addr,
  output byte_t wr_data,
  output logic  mdo,
  output logic  mdo_oe
);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] SAT      = '1;

  logic                   active;
  logic [CNT_W-1:0]       bit_cnt;
  logic [FRAME_W-1:0]     rx_sh;
  logic                   rw_q;
  logic                   load_pend;
  logic                   rd_mode;
  byte_t                  tx_sh;
  logic [$clog2(BYTE_W)-1:0] tx_cnt;
  idx_t                   rd_cur;
  idx_t                   rd_last;
  idx_t                   start_idx;

  assign start_idx = sweep ? idx_t'(1) : ptr;
  assign rd_addr   = load_pend ? start_idx : idx_t'(rd_cur + 1'b1);

  assign wr_en   = ml_rise && active && !rw_q && (bit_cnt == FULL);
  assign wr_addr = rx_sh[FRAME_W-2 -: IDX_W];
  assign wr_data = rx_sh[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rw_q      <= 1'b0;
      load_pend <= 1'b0;
      rd_mode   <= 1'b0;
      tx_sh     <= '0;
      tx_cnt    <= '0;
      rd_cur    <= '0;
      rd_last   <= '0;
      mdo       <= 1'b0;
      mdo_oe    <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (ml_fall) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        rw_q    <= 1'b0;
        rd_mode <= 1'b0;
        mdo_oe  <= 1'b0;
        tx_cnt  <= '0;
      end else if (ml_rise) begin
        active  <= 1'b0;
        rd_mode <= 1'b0;
        mdo_oe  <= 1'b0;
      end else if (active) begin
        if (mc_rise) begin
          rx_sh <= {rx_sh[FRAME_W-2:0], mdi};
          if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CMD_LAST) begin
            rw_q      <= rx_sh[BYTE_W-2];
            load_pend <= rx_sh[BYTE_W-2];
          end
        end
        if (load_pend) begin
          rd_mode <= 1'b1;
          tx_sh   <= rd_data;
          rd_cur  <= start_idx;
          rd_last <= ptr;
          tx_cnt  <= '0;
        end
        if (mc_fall && rd_mode) begin
          mdo    <= tx_sh[BYTE_W-1];
          mdo_oe <= 1'b1;
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == '1) begin
            if (rd_cur < rd_last) begin
              tx_sh  <= rd_data;
              rd_cur <= rd_addr;
            end else begin
              tx_sh <= '0;
            end
          end else begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scp_pkg::*;
#(
  parameter int    NUM_REGS    = 16,
  parameter int    SETUP_IDX   = 11,
  parameter int    SYNC_STAGES = 2,
  parameter byte_t SETUP_RST   = 8'h01,
  parameter byte_t REG_RST     = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ml_i,
  input  logic                       mc_i,
  input  logic                       mdi_i,
  output logic                       mdo_o,
  output logic                       mdo_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  logic [2:0] s_lvl, s_rise, s_fall;
  logic  ml_lvl, ml_rise, ml_fall, mc_rise, mc_fall, mdi_s;
  logic  sweep, wr_en;
  idx_t  ptr, rd_addr, wr_addr;
  byte_t rd_data, wr_data;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .async_i({mdi_i, mc_i, ml_i}),
    .lvl_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall)
  );

  assign ml_lvl  = s_lvl[0];
  assign ml_rise = s_rise[0];
  assign ml_fall = s_fall[0];
  assign mc_rise = s_rise[1];
  assign mc_fall = s_fall[1];
  assign mdi_s   = s_lvl[2];

  scp_regbank #(
    .NUM_REGS(NUM_REGS), .SETUP_IDX(SETUP_IDX),
    .SETUP_RST(SETUP_RST), .REG_RST(REG_RST)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sweep_o(sweep), .ptr_o(ptr),
    .cfg_o(cfg_o)
  );

  scp_frame u_frame (
    .clk(clk), .rst(rst), .ml_rise(ml_rise), .ml_fall(ml_fall),
    .mc_rise(mc_rise), .mc_fall(mc_fall), .mdi(mdi_s), .sweep(sweep),
    .ptr(ptr), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mdo(mdo_o), .mdo_oe(mdo_oe_o)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int CFG_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             ml_lvl,
  input logic             mc_fall,
  input logic             wr_en,
  input logic             mdo_o,
  input logic             mdo_oe_o,
  input logic [CFG_W-1:0] cfg_o
);
  // R10 / R4: strobe high forces the driver off on the next cycle
  p_idle_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    ml_lvl |=> !mdo_oe_o);

  // R2: stores only happen while the strobe is high (at its rising edge)
  p_store_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ml_lvl);

  // R3: with no store request the bank holds its contents
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o));

  // R5: the driver only turns on right after a serial clock falling edge
  p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mdo_oe_o) |-> $past(mc_fall));

  // R5: output data only moves after a serial clock falling edge
  p_data_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !mc_fall |=> $stable(mdo_o));
endmodule

bind serial_cfg_port scp_checker #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst(rst), .ml_lvl(ml_lvl), .mc_fall(mc_fall), .wr_en(wr_en),
  .mdo_o(mdo_o), .mdo_oe_o(mdo_oe_o), .cfg_o(cfg_o)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
  localparam int NUM  = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ml_i = 1'b1, mc_i = 1'b0, mdi_i = 1'b0;
  logic mdo_o, mdo_oe_o;
  logic [NUM*8-1:0] cfg_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit cmd_phase = 0, rd_phase = 0;
  logic [7:0] mdl [NUM];
  logic [7:0] expq [$];
  logic [7:0] mon_sh = '0;
  int mon_nb = 0;

  always #10 clk = ~clk;

  serial_cfg_port #(.NUM_REGS(NUM)) u0 (
    .clk(clk), .rst(rst), .ml_i(ml_i), .mc_i(mc_i), .mdi_i(mdi_i),
    .mdo_o(mdo_o), .mdo_oe_o(mdo_oe_o), .cfg_o(cfg_o)
  );

  task automatic check(input string req, input logic [NUM*8-1:0] act, input logic [NUM*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NUM*8-1:0] model_flat();
    logic [NUM*8-1:0] f;
    for (int k = 0; k < NUM; k++) f[k*8 +: 8] = mdl[k];
    return f;
  endfunction

  // monitor: scoreboard side
  always @(posedge mc_i) begin
    if (cmd_phase) begin
      mon_nb = 0;
      check("R4 oe in command", {127'd0, mdo_oe_o}, '0);
    end else if (rd_phase) begin
      if (mdo_oe_o !== 1'b1) check("R5 oe in data", {127'd0, mdo_oe_o}, 1);
      mon_sh = {mon_sh[6:0], mdo_o};
      mon_nb++;
      if (mon_nb == 8) begin
        mon_nb = 0;
        if (expq.size() == 0) check("R6 unexpected byte", {120'd0, mon_sh}, '1);
        else check("R5/R6 read byte", {120'd0, mon_sh}, {120'd0, expq.pop_front()});
      end
    end
  end

  task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nclk);
    ml_i = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mdi_i = (i < 8) ? cmd[7-i] : ((i < 16) ? dat[15-i] : i[0]);
      cmd_phase = (i < 8);
      rd_phase  = (i >= 8) && cmd[7];
      repeat (HALF) @(negedge clk);
      mc_i = 1'b1;
      repeat (HALF) @(negedge clk);
      mc_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    cmd_phase = 0;
    rd_phase  = 0;
    ml_i = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [7:0] dat, input int nclk);
    frame({1'b0, 7'(idx)}, dat, nclk);
    if (nclk == 16 && idx < NUM) mdl[idx] = dat;
  endtask

  initial begin
    for (int k = 0; k < NUM; k++) mdl[k] = 8'h00;
    mdl[11] = 8'h01;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 reset bank", cfg_o, model_flat());
    check("R1 reset oe", {127'd0, mdo_oe_o}, '0);

    // R2 writes
    wr(1, 8'h81, 16); wr(2, 8'h7E, 16); wr(3, 8'hA5, 16);
    wr(4, 8'h5A, 16); wr(5, 8'h3C, 16); wr(0, 8'hF0, 16);
    check("R2 writes stored", cfg_o, model_flat());

    // R3 short and long frames
    wr(3, 8'h11, 12);
    check("R3 short frame ignored", cfg_o, model_flat());
    wr(3, 8'h22, 17);
    check("R3 long frame ignored", cfg_o, model_flat());

    // R9 / R5 single read of register 3
    wr(11, 8'h03, 16);
    check("R9 setup written", cfg_o, model_flat());
    expq.push_back(mdl[3]);
    frame(8'h80, 8'h00, 16);
    // R7 nonzero index and noisy input in read frame
    expq.push_back(mdl[3]);
    frame(8'h85, 8'hFF, 20);
    check("R7 read frame leaves bank", cfg_o, model_flat());

    // R6 sweep read 1..4
    wr(11, 8'h84, 16);
    for (int k = 1; k <= 4; k++) expq.push_back(mdl[k]);
    frame(8'h80, 8'h00, 40);

    // R8 pointer beyond bank, write beyond bank
    wr(11, 8'h64, 16);
    expq.push_back(8'h00);
    frame(8'h80, 8'h00, 16);
    wr(100, 8'hEE, 16);
    check("R8 out of range write ignored", cfg_o, model_flat());

    // R10 abort a read mid-byte
    wr(11, 8'h02, 16);
    ml_i = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      mdi_i = (i == 0);
      cmd_phase = (i < 8);
      repeat (HALF) @(negedge clk); mc_i = 1'b1;
      repeat (HALF) @(negedge clk); mc_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R10 oe on during read", {127'd0, mdo_oe_o}, 1);
    cmd_phase = 0;
    ml_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 oe off after abort", {127'd0, mdo_oe_o}, '0);
    check("R6 all expected bytes seen", 128'(expq.size()), '0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule